// File: doc/BRIEF.md
# Two-Register 8-bit Mini Processor

This block is a very small 8-bit processor core with two general registers, R0 and R1. It does not fetch anything itself. Outside logic places a 16-bit instruction word on its inputs and then drives two active-low strobes in turn. While the execute strobe is low, the core decodes the word and captures the ALU result in an internal result latch. On the rising edge of the update strobe, that result is committed to the destination register, or to the display-select register for an OUT instruction. The two strobes are never low at the same time.

The ALU supports add, subtract, XOR, AND, two's-complement negate, one-bit shifts left and right, and loading an 8-bit immediate. Register codes sit in 3-bit fields of the instruction. Only codes 000 (R0) and 001 (R1) are valid. A word with any other register code, or with an opcode the core does not recognise, does nothing. Two seven-segment drivers show an 8-bit value as two hex digits. That value is R0 until an OUT instruction selects another register.

Everything is synchronous to `clk`. The strobes are sampled on its rising edge, and `rst` is an active-high synchronous reset.

Top module: `mini8_core`

## Requirements
- R1: While `rst` is high at a clock edge, R0, R1 and the result latch are cleared and the display selects R0, so both digits show 0.
- R2: MOV Rd,#imm8 is encoded `00100 ddd iiiiiiii` and writes imm8 to Rd.
- R3: ADD Rd,Rn,Rm is `0001100 mmm nnn ddd` and SUB Rd,Rn,Rm is `0001101 mmm nnn ddd`. They write Rn+Rm and Rn-Rm to Rd, wrapping modulo 256.
- R4: ADD Rd,Rn,#imm3 is `0001110 iii nnn ddd` and SUB Rd,Rn,#imm3 is `0001111 iii nnn ddd`. They write Rn plus or minus the zero-extended imm3 to Rd, wrapping modulo 256.
- R5: The format `010000 oooo mmm ddd` with oooo=0000 writes Rd AND Rm to Rd, and with oooo=0001 writes Rd XOR Rm to Rd.
- R6: In the same format, oooo=0010 writes Rm shifted left by one to Rd, 0011 writes Rm shifted right by one to Rd, and 1001 writes 0-Rm modulo 256 to Rd. Shifts fill with zero.
- R7: A result is captured only while `exe_n` is low. Registers and display selection change only at the clock edge where `upd_n` is first seen high after being low. An execute phase alone changes no visible state.
- R8: OUT Rd is `0100011100000 ddd` and makes the display show Rd from then on. Before any OUT, the display shows R0 and follows its changes.
- R9: A word with a register field other than 000 or 001, or an unrecognised opcode, leaves R0, R1 and the display selection unchanged.
- R10: A captured result is committed once. A second update pulse with no execute phase in between changes nothing.
- R11: `seg_hi_o` shows the upper nibble and `seg_lo_o` the lower nibble of the displayed value. Bit 0 is segment a through bit 6 as segment g, and a 1 lights a segment, using the usual hex glyphs (0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F, A=77, b=7C, C=39, d=5E, E=79, F=71).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_i | input | 16 | Instruction word |
| exe_n_i | input | 1 | Execute strobe, active low |
| upd_n_i | input | 1 | Update strobe, active low; commits on its rising edge |
| seg_hi_o | output | 7 | Segments of the upper hex digit (bit 0 = a) |
| seg_lo_o | output | 7 | Segments of the lower hex digit (bit 0 = a) |

## Verification
The assertions check on every cycle that the strobes are never low together. They also check that the registers and the display selection stay still except at an update rising edge. Finally, they check that MOV and LSL put the correct value in the result latch during the execute phase. The arithmetic results, the OUT selection, the single-commit rule, the no-op handling of bad codes and the glyph encoding are visible only at the display. They are shown by the bench's instruction sequences, which are built so that every result appears on the digits through R0 or through OUT.

// File: rtl/mini8_pkg.sv
package mini8_pkg;
    localparam int DW    = 8;            // data width
    localparam int IW    = 16;           // instruction width
    localparam int RW    = 3;            // register field width
    localparam int NREG  = 2;            // implemented registers
    localparam int IDX_W = $clog2(NREG);
    localparam int NIB   = 4;
    localparam int NDIG  = DW / NIB;     // display digits
    localparam int SEG_W = 7;

    typedef enum logic [2:0] {
        ALU_PASS, ALU_ADD, ALU_SUB, ALU_AND, ALU_EOR, ALU_LSL, ALU_LSR, ALU_NEG
    } alu_op_e;

    typedef enum logic [1:0] {
        ACT_NONE, ACT_WRITE, ACT_SHOW
    } action_e;

    typedef struct packed {
        action_e              action;
        alu_op_e              op;
        logic [IDX_W-1:0]     rd;
        logic [IDX_W-1:0]     src_a;
        logic [IDX_W-1:0]     src_b;
        logic                 use_imm;
        logic [DW-1:0]        imm;
    } decoded_t;

    typedef struct packed {
        action_e              act;
        logic [IDX_W-1:0]     rd;
        logic [DW-1:0]        data;
    } pending_t;

    typedef struct packed {
        logic [NREG-1:0][DW-1:0] regs;
        logic [IDX_W-1:0]        show;
        logic                    upd_prev;
        pending_t                pend;
    } core_state_t;
endpackage

// File: rtl/mini8_decode.sv
module mini8_decode
    import mini8_pkg::*;
(
    input  logic [IW-1:0] instr_i,
    output decoded_t      dec_o
);
    localparam logic [4:0]  OPC_MOV   = 5'b00100;
    localparam logic [5:0]  OPC_ARR   = 6'b000110;
    localparam logic [5:0]  OPC_ARI   = 6'b000111;
    localparam logic [5:0]  OPC_DP    = 6'b010000;
    localparam logic [12:0] OPC_SHOW  = 13'b0100011100000;

    logic [RW-1:0] f_lo, f_mid, f_hi, f_mov;
    logic          ok;
    decoded_t      d;

    function automatic logic reg_ok(input logic [RW-1:0] r);
        return r < RW'(NREG);
    endfunction

    assign f_lo  = instr_i[2:0];
    assign f_mid = instr_i[5:3];
    assign f_hi  = instr_i[8:6];
    assign f_mov = instr_i[10:8];

    always_comb begin
        d         = '0;
        d.action  = ACT_NONE;
        d.op      = ALU_PASS;
        ok        = 1'b0;
        d.rd      = f_lo[IDX_W-1:0];
        if (instr_i[15:11] == OPC_MOV) begin
            d.op      = ALU_PASS;
            d.use_imm = 1'b1;
            d.imm     = instr_i[DW-1:0];
            d.rd      = f_mov[IDX_W-1:0];
            ok        = reg_ok(f_mov);
        end else if (instr_i[15:10] == OPC_ARR) begin
            d.op    = instr_i[9] ? ALU_SUB : ALU_ADD;
            d.src_a = f_mid[IDX_W-1:0];
            d.src_b = f_hi[IDX_W-1:0];
            ok      = reg_ok(f_lo) && reg_ok(f_mid) && reg_ok(f_hi);
        end else if (instr_i[15:10] == OPC_ARI) begin
            d.op      = instr_i[9] ? ALU_SUB : ALU_ADD;
            d.src_a   = f_mid[IDX_W-1:0];
            d.use_imm = 1'b1;
            d.imm     = {{(DW-3){1'b0}}, f_hi};
            ok        = reg_ok(f_lo) && reg_ok(f_mid);
        end else if (instr_i[15:10] == OPC_DP) begin
            d.src_a = f_lo[IDX_W-1:0];
            d.src_b = f_mid[IDX_W-1:0];
            ok      = reg_ok(f_lo) && reg_ok(f_mid);
            unique case (instr_i[9:6])
                4'b0000: d.op = ALU_AND;
                4'b0001: d.op = ALU_EOR;
                4'b0010: d.op = ALU_LSL;
                4'b0011: d.op = ALU_LSR;
                4'b1001: d.op = ALU_NEG;
                default: ok   = 1'b0;
            endcase
        end else if (instr_i[15:3] == OPC_SHOW) begin
            ok = reg_ok(f_lo);
        end
        if (ok) begin
            d.action = (instr_i[15:3] == OPC_SHOW) ? ACT_SHOW : ACT_WRITE;
        end
    end

    assign dec_o = d;
endmodule

// File: rtl/mini8_alu.sv
module mini8_alu
    import mini8_pkg::*;
(
    input  alu_op_e       op_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    output logic [DW-1:0] y_o
);
    always_comb begin
        unique case (op_i)
            ALU_ADD:  y_o = a_i + b_i;
            ALU_SUB:  y_o = a_i - b_i;
            ALU_AND:  y_o = a_i & b_i;
            ALU_EOR:  y_o = a_i ^ b_i;
            ALU_LSL:  y_o = {b_i[DW-2:0], 1'b0};
            ALU_LSR:  y_o = {1'b0, b_i[DW-1:1]};
            ALU_NEG:  y_o = '0 - b_i;
            default:  y_o = b_i;
        endcase
    end
endmodule

// File: rtl/mini8_hexseg.sv
module mini8_hexseg
    import mini8_pkg::*;
(
    input  logic [NIB-1:0]   nib_i,
    output logic [SEG_W-1:0] seg_o
);
    always_comb begin
        unique case (nib_i)
            4'h0: seg_o = 7'h3F;
            4'h1: seg_o = 7'h06;
            4'h2: seg_o = 7'h5B;
            4'h3: seg_o = 7'h4F;
            4'h4: seg_o = 7'h66;
            4'h5: seg_o = 7'h6D;
            4'h6: seg_o = 7'h7D;
            4'h7: seg_o = 7'h07;
            4'h8: seg_o = 7'h7F;
            4'h9: seg_o = 7'h6F;
            4'hA: seg_o = 7'h77;
            4'hB: seg_o = 7'h7C;
            4'hC: seg_o = 7'h39;
            4'hD: seg_o = 7'h5E;
            4'hE: seg_o = 7'h79;
            default: seg_o = 7'h71;
        endcase
    end
endmodule

// File: rtl/mini8_core.sv
module mini8_core
    import mini8_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IW-1:0]    instr_i,
    input  logic             exe_n_i,
    input  logic             upd_n_i,
    output logic [SEG_W-1:0] seg_hi_o,
    output logic [SEG_W-1:0] seg_lo_o
);
    decoded_t            dec;
    logic [DW-1:0]       opa, opb, alu_y, shown;
    logic [NDIG-1:0][SEG_W-1:0] segs;
    core_state_t         st_d, st_q;
    logic                commit;

    mini8_decode u_dec (.instr_i(instr_i), .dec_o(dec));

    assign opa = st_q.regs[dec.src_a];
    assign opb = dec.use_imm ? dec.imm : st_q.regs[dec.src_b];

    mini8_alu u_alu (.op_i(dec.op), .a_i(opa), .b_i(opb), .y_o(alu_y));

    assign commit = upd_n_i && !st_q.upd_prev;

    always_comb begin
        st_d          = st_q;
        st_d.upd_prev = upd_n_i;
        if (!exe_n_i) begin
            st_d.pend.act  = dec.action;
            st_d.pend.rd   = dec.rd;
            st_d.pend.data = alu_y;
        end else if (commit) begin
            unique case (st_q.pend.act)
                ACT_WRITE: st_d.regs[st_q.pend.rd] = st_q.pend.data;
                ACT_SHOW:  st_d.show = st_q.pend.rd;
                default:   ;
            endcase
            st_d.pend.act = ACT_NONE;
        end
        if (rst) begin
            st_d          = '0;
            st_d.pend.act = ACT_NONE;
            st_d.upd_prev = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign shown = st_q.regs[st_q.show];

    for (genvar g = 0; g < NDIG; g++) begin : g_digit
        mini8_hexseg u_seg (.nib_i(shown[g*NIB +: NIB]), .seg_o(segs[g]));
    end

    assign seg_hi_o = segs[NDIG-1];
    assign seg_lo_o = segs[0];
endmodule

// File: rtl/mini8_core_chk.sv
module mini8_core_chk
    import mini8_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic [IW-1:0]           instr_i,
    input logic                    exe_n_i,
    input logic                    upd_n_i,
    input logic [NREG-1:0][DW-1:0] regs,
    input logic [IDX_W-1:0]        show,
    input logic [DW-1:0]           pend_data
);
    // R7: the two strobes are never low together
    a_r7_strobes_apart: assert property (@(posedge clk) disable iff (rst)
        !(!exe_n_i && !upd_n_i));

    // R7: registers move only at an update rising edge
    a_r7_regs_hold: assert property (@(posedge clk) disable iff (rst)
        !(upd_n_i && !$past(upd_n_i)) |=> $stable(regs));

    // R8: display selection moves only at an update rising edge
    a_r8_show_hold: assert property (@(posedge clk) disable iff (rst)
        !(upd_n_i && !$past(upd_n_i)) |=> $stable(show));

    // R2: a valid MOV captures its immediate
    a_r2_mov_capture: assert property (@(posedge clk) disable iff (rst)
        (!exe_n_i && instr_i[15:11] == 5'b00100 && instr_i[10:8] < 3'(NREG))
        |=> pend_data == $past(instr_i[7:0]));

    // R6: LSL of R0 captures R0 doubled
    a_r6_lsl_capture: assert property (@(posedge clk) disable iff (rst)
        (!exe_n_i && instr_i[15:6] == 10'b0100000010 && instr_i[5:3] == 3'd0
         && instr_i[2:0] < 3'(NREG))
        |=> pend_data == DW'($past(regs[0]) << 1));
endmodule

bind mini8_core mini8_core_chk u_chk (
    .clk(clk), .rst(rst), .instr_i(instr_i), .exe_n_i(exe_n_i),
    .upd_n_i(upd_n_i), .regs(st_q.regs), .show(st_q.show),
    .pend_data(st_q.pend.data)
);

// File: tb/test_mini8_core.sv
`timescale 1ns/1ps
module test_mini8_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] instr = 16'h0000;
    logic        exe_n = 1'b1;
    logic        upd_n = 1'b1;
    logic [6:0]  seg_hi, seg_lo;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    mini8_core i_mini8_core (
        .clk(clk), .rst(rst), .instr_i(instr), .exe_n_i(exe_n),
        .upd_n_i(upd_n), .seg_hi_o(seg_hi), .seg_lo_o(seg_lo)
    );

    function automatic logic [6:0] glyph(input logic [3:0] n);
        logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                               7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
        return t[n];
    endfunction

    task automatic check(input string tag, input logic [7:0] exp);
        logic [13:0] want;
        want = {glyph(exp[7:4]), glyph(exp[3:0])};
        n_run++;
        if ({seg_hi, seg_lo} !== want) begin
            n_fail++;
            $display("FAIL %s: segments %h expected %h (value %h)", tag, {seg_hi, seg_lo}, want, exp);
        end
    endtask

    task automatic run(input logic [15:0] w);
        @(negedge clk) instr = w; exe_n = 1'b0;
        @(negedge clk) exe_n = 1'b1;
        @(negedge clk) upd_n = 1'b0;
        @(negedge clk) upd_n = 1'b1;
        @(negedge clk);
    endtask

    typedef struct packed { logic [15:0] w; logic [7:0] exp; } vec_t;
    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{16'h205A, 8'h5A},  // R2 MOV R0,#5A
        '{16'h21C3, 8'h5A},  // R2 MOV R1,#C3, display stays on R0 (R8)
        '{16'h4701, 8'hC3},  // R8 OUT R1
        '{16'h1840, 8'hC3},  // R3 ADD R0,R0,R1 -> 1D, display on R1
        '{16'h4700, 8'h1D},  // R8 OUT R0, R3 wrap result
        '{16'h1A40, 8'h5A},  // R3 SUB R0,R0,R1 wrap
        '{16'h1DC0, 8'h61},  // R4 ADD R0,R0,#7
        '{16'h1EC0, 8'h5E},  // R4 SUB R0,R0,#3
        '{16'h4008, 8'h42},  // R5 AND R0,R1
        '{16'h4048, 8'h81},  // R5 EOR R0,R1
        '{16'h4080, 8'h02},  // R6 LSL R0,R0 drops top bit
        '{16'h40C8, 8'h61},  // R6 LSR R0,R1
        '{16'h4248, 8'h3D},  // R6 NEG R0,R1
        '{16'h22FF, 8'h3D},  // R9 MOV to code 010
        '{16'h4108, 8'h3D},  // R9 unknown data-processing op
        '{16'h1880, 8'h3D},  // R9 ADD with Rm code 010
        '{16'h4702, 8'h3D},  // R9 OUT of code 010
        '{16'hFFFF, 8'h3D},  // R9 unrecognised opcode
        '{16'h1A40, 8'h7A},  // R3 SUB R0,R0,R1 underflow wrap
        '{16'h40C1, 8'h7A},  // R6 LSR R1,R0, display on R0
        '{16'h4701, 8'h3D}   // R8 OUT R1 shows shifted value
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset shows R0=00", 8'h00);

        for (int i = 0; i < NV; i++) begin
            run(VEC[i].w);
            check($sformatf("vector %0d", i), VEC[i].exp);
        end

        // R7: execute phase alone changes nothing
        run(16'h4700);                       // back to R0 (=7A)
        @(negedge clk) instr = 16'h20AA; exe_n = 1'b0;
        @(negedge clk) exe_n = 1'b1;
        @(negedge clk);
        check("R7 no commit without update", 8'h7A);
        @(negedge clk) upd_n = 1'b0;
        @(negedge clk) upd_n = 1'b1;
        @(negedge clk);
        check("R7 commit on update rise", 8'hAA);

        // R10: second update pulse does not repeat the add
        run(16'h1C00);                       // ADD R0,R0,#0 ... use #1 below
        run(16'h1C40);                       // ADD R0,R0,#1 -> AB
        check("R10 first commit", 8'hAB);
        @(negedge clk) upd_n = 1'b0;
        @(negedge clk) upd_n = 1'b1;
        @(negedge clk);
        check("R10 repeated update ignored", 8'hAB);

        // R11: every glyph on both digits
        for (int n = 0; n < 16; n++) begin
            run({8'h20, 4'(n), 4'(15 - n)});
            check($sformatf("R11 glyph %0d", n), {4'(n), 4'(15 - n)});
        end

        // R1: reset mid-run clears registers and display selection
        run(16'h2177);                       // R1 = 77
        run(16'h4701);                       // show R1
        check("R8 show R1 before reset", 8'h77);
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        check("R1 reset clears", 8'h00);
        run(16'h21AB);                       // R1 = AB, display must stay on R0
        check("R1 display back on R0", 8'h00);
        run(16'h4701);
        check("R1 R1 writable after reset", 8'hAB);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule